// File: doc/BRIEF.md
# Multicycle-Hold Compare Controller

This block is a small control-plus-datapath unit. A register file, an ALU and two operand multiplexers form the datapath, and a state machine drives them through a packed bundle of strobes. The ALU's equality compare is deliberately slow: its output only becomes trustworthy a fixed number of cycles after its inputs change. To absorb that, the compare state keeps every control strobe frozen for a parameterised power-of-two number of cycles. A per-state counter tracks those cycles, and the result is committed to the register file only on the final one.

In use, software-free operation looks like this. Raising `go` in idle loads `loadValue` into the score register (register 1). The machine then compares the score with the constant 10 and writes the 0/1 outcome into the temp register (register 6). A branch state reads that temp register. On a match the machine parks in a matched state until `go` falls. Otherwise it adds one to the score and compares again. The register-file write bus is brought out at the ports so the behaviour can be observed.

Top module: `hold_ctrl_top`

## Requirements
- R1: Each visit to the compare state lasts exactly 2^HOLD_BITS clock cycles, which is 16 with the default HOLD_BITS of 4. The hold counter advances by one on every one of those cycles.
- R2: On every cycle of the compare state, the control strobes keep the same values, and `wrAddr` reads 6 throughout.
- R3: `wrEn` is high for exactly one cycle per compare visit. That cycle is the last one, and `stateCode` shows the branch state on the next cycle.
- R4: The hold counter is zero on entry to every compare visit, including the first visit after a reset that interrupted a compare.
- R5: The compare write puts 1 into register 6 when register 1 equals 10, and 0 otherwise. The value written is the settled compare result, not the stale ALU output left over from before the state was entered. This holds because the ALU latency ALU_LAT is below 2^HOLD_BITS.
- R6: In the branch state no write occurs. The next state is matched when register 6 holds 1, and the increment state otherwise.
- R7: The increment state writes the value of register 1 plus one into register 1 (`wrAddr` 1, `wrEn` high for that single cycle), then returns to compare.
- R8: In idle, `go` high moves to the load state. The load state writes `loadValue` into register 1 in a single cycle, then goes to compare. In idle, `go` low keeps the block in idle with no write.
- R9: The matched state stays put while `go` is high and returns to idle on the cycle after `go` is seen low. `matched` is high exactly while `stateCode` is 5.
- R10: Synchronous active-high `rst` returns the block to idle (`stateCode` 0) with `wrEn` low, clears the hold counter and clears all registers.
- R11: `stateCode` encodes the states as follows: idle 0, load 1, compare 2, branch 3, increment 4, matched 5.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| go | input | 1 | Start request in idle; release request in matched |
| loadValue | input | DATA_W | Initial score loaded into register 1 |
| stateCode | output | 3 | Current state encoding |
| wrEn | output | 1 | Register-file write strobe |
| wrAddr | output | 3 | Register-file write address |
| wrData | output | DATA_W | Register-file write data (ALU result) |
| matched | output | 1 | High while in the matched state |

## Verification
A hold counter that starts from the wrong value or wraps at the wrong count shows up within one compare visit. Either the visit length differs from 16 cycles, or the single `wrEn` pulse moves off the last cycle. A commit that comes too early exposes the stale ALU output on `wrData` at that same pulse, so a wrong value reaches register 6. A wrong branch decision, or a lost or duplicated increment, shows up as a wrong `stateCode` one cycle after the compare commit. It also shows as a wrong `wrData` on the next increment or load write.

// File: rtl/holdfsm_pkg.sv
package holdfsm_pkg;
  localparam int REG_COUNT = 8;
  localparam int REG_AW = $clog2(REG_COUNT);

  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_LOAD  = 3'd1,
    ST_CMP   = 3'd2,
    ST_BR    = 3'd3,
    ST_INC   = 3'd4,
    ST_DONE  = 3'd5
  } state_e;

  localparam logic [5:0] FN_ADD   = 6'b000000;
  localparam logic [5:0] FN_PASSB = 6'b011010;
  localparam logic [5:0] FN_CMPEQ = 6'b110011;

  localparam logic [1:0] ASEL_RD  = 2'b00;
  localparam logic [1:0] ASEL_ZERO = 2'b01;

  localparam logic [1:0] BSEL_RD  = 2'b00;
  localparam logic [1:0] BSEL_K   = 2'b01;
  localparam logic [1:0] BSEL_EXT = 2'b10;
  localparam logic [1:0] BSEL_ONE = 2'b11;

  localparam logic [REG_AW-1:0] REG_SCORE = 3'd1;
  localparam logic [REG_AW-1:0] REG_TEMP  = 3'd6;

  typedef struct packed {
    logic [5:0]        aluFn;
    logic [REG_AW-1:0] rdAddrA;
    logic [REG_AW-1:0] rdAddrB;
    logic [1:0]        aSel;
    logic [1:0]        bSel;
    logic [REG_AW-1:0] wrAddr;
    logic              wrEn;
  } ctrl_t;
endpackage

// File: rtl/hold_regfile.sv
module hold_regfile #(
  parameter int DATA_W = 16,
  parameter int DEPTH  = 8,
  localparam int AW    = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [AW-1:0]     rdAddrA,
  input  logic [AW-1:0]     rdAddrB,
  input  logic              wrEn,
  input  logic [AW-1:0]     wrAddr,
  input  logic [DATA_W-1:0] wrData,
  output logic [DATA_W-1:0] rdDataA,
  output logic [DATA_W-1:0] rdDataB
);
  logic [DATA_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
    end else if (wrEn && wrAddr != '0) begin
      mem[wrAddr] <= wrData;
    end
  end

  assign rdDataA = (rdAddrA == '0) ? '0 : mem[rdAddrA];
  assign rdDataB = (rdAddrB == '0) ? '0 : mem[rdAddrB];
endmodule

// File: rtl/hold_slow_alu.sv
module hold_slow_alu
  import holdfsm_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int LAT    = 6,
  localparam int CNT_W = $clog2(LAT + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [5:0]        fn,
  input  logic [DATA_W-1:0] opA,
  input  logic [DATA_W-1:0] opB,
  output logic [DATA_W-1:0] result,
  output logic              settled
);
  logic [5:0]        prevFn;
  logic [DATA_W-1:0] prevA, prevB, heldOut, exact;
  logic [CNT_W-1:0]  stableCnt;
  logic              changed;

  assign changed = (fn != prevFn) || (opA != prevA) || (opB != prevB);
  assign settled = !changed && (stableCnt >= CNT_W'(LAT - 1));

  always_comb begin
    case (fn)
      FN_ADD:   exact = opA + opB;
      FN_PASSB: exact = opB;
      FN_CMPEQ: exact = {{(DATA_W-1){1'b0}}, opA == opB};
      default:  exact = '0;
    endcase
  end

  // only the compare path is slow; until it settles, the previous output persists
  assign result = (fn == FN_CMPEQ && !settled) ? heldOut : exact;

  always_ff @(posedge clk) begin
    if (rst) begin
      prevFn    <= '0;
      prevA     <= '0;
      prevB     <= '0;
      stableCnt <= '0;
      heldOut   <= '0;
    end else begin
      prevFn  <= fn;
      prevA   <= opA;
      prevB   <= opB;
      heldOut <= result;
      if (changed) stableCnt <= '0;
      else if (stableCnt < CNT_W'(LAT)) stableCnt <= stableCnt + 1'b1;
    end
  end
endmodule

// File: rtl/hold_datapath.sv
module hold_datapath
  import holdfsm_pkg::*;
#(
  parameter int DATA_W    = 16,
  parameter int ALU_LAT   = 6,
  parameter int CMP_CONST = 10
) (
  input  logic              clk,
  input  logic              rst,
  input  ctrl_t             ctrl,
  input  logic [DATA_W-1:0] loadValue,
  output logic [DATA_W-1:0] wrData,
  output logic              flagOne
);
  logic [DATA_W-1:0] rdA, rdB, opA, opB, aluOut;
  logic              aluSettled;

  hold_regfile #(.DATA_W(DATA_W), .DEPTH(REG_COUNT)) u_rf (
    .clk(clk), .rst(rst),
    .rdAddrA(ctrl.rdAddrA), .rdAddrB(ctrl.rdAddrB),
    .wrEn(ctrl.wrEn), .wrAddr(ctrl.wrAddr), .wrData(aluOut),
    .rdDataA(rdA), .rdDataB(rdB)
  );

  always_comb begin
    opA = (ctrl.aSel == ASEL_ZERO) ? '0 : rdA;
    case (ctrl.bSel)
      BSEL_RD:  opB = rdB;
      BSEL_K:   opB = DATA_W'(CMP_CONST);
      BSEL_EXT: opB = loadValue;
      default:  opB = DATA_W'(1);
    endcase
  end

  hold_slow_alu #(.DATA_W(DATA_W), .LAT(ALU_LAT)) u_alu (
    .clk(clk), .rst(rst), .fn(ctrl.aluFn), .opA(opA), .opB(opB),
    .result(aluOut), .settled(aluSettled)
  );

  assign wrData  = aluOut;
  assign flagOne = (rdA == DATA_W'(1));

  // R5: a compare result may only be committed once the slow path has settled
  a_r5_commit_settled: assert property (@(posedge clk) disable iff (rst)
    (ctrl.wrEn && ctrl.aluFn == FN_CMPEQ) |-> aluSettled);
endmodule

// File: rtl/hold_controller.sv
module hold_controller
  import holdfsm_pkg::*;
#(
  parameter int HOLD_BITS = 4
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       go,
  input  logic       flagOne,
  output ctrl_t      ctrl,
  output logic [2:0] stateCode
);
  state_e               state, stateNext;
  logic [HOLD_BITS-1:0] holdCnt, holdNext;

  always_comb begin
    ctrl      = '0;
    stateNext = state;
    holdNext  = '0;
    case (state)
      ST_IDLE: if (go) stateNext = ST_LOAD;
      ST_LOAD: begin
        ctrl.aluFn  = FN_PASSB;
        ctrl.aSel   = ASEL_ZERO;
        ctrl.bSel   = BSEL_EXT;
        ctrl.wrAddr = REG_SCORE;
        ctrl.wrEn   = 1'b1;
        stateNext   = ST_CMP;
      end
      ST_CMP: begin
        ctrl.aluFn   = FN_CMPEQ;
        ctrl.rdAddrA = REG_SCORE;
        ctrl.aSel    = ASEL_RD;
        ctrl.bSel    = BSEL_K;
        ctrl.wrAddr  = REG_TEMP;
        if (&holdCnt) begin
          ctrl.wrEn = 1'b1;
          stateNext = ST_BR;
        end else begin
          holdNext = holdCnt + 1'b1;
        end
      end
      ST_BR: begin
        ctrl.rdAddrA = REG_TEMP;
        stateNext    = flagOne ? ST_DONE : ST_INC;
      end
      ST_INC: begin
        ctrl.aluFn   = FN_ADD;
        ctrl.rdAddrA = REG_SCORE;
        ctrl.aSel    = ASEL_RD;
        ctrl.bSel    = BSEL_ONE;
        ctrl.wrAddr  = REG_SCORE;
        ctrl.wrEn    = 1'b1;
        stateNext    = ST_CMP;
      end
      ST_DONE: if (!go) stateNext = ST_IDLE;
      default: stateNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state   <= ST_IDLE;
      holdCnt <= '0;
    end else begin
      state   <= stateNext;
      holdCnt <= holdNext;
    end
  end

  assign stateCode = state;

  // R1: each non-terminal compare cycle steps the counter by one
  a_r1_count_step: assert property (@(posedge clk) disable iff (rst)
    (state == ST_CMP && !ctrl.wrEn) |=> (state == ST_CMP && holdCnt == $past(holdCnt) + 1'b1));
  // R2: strobes frozen while resident in compare
  a_r2_ctrl_frozen: assert property (@(posedge clk) disable iff (rst)
    (state == ST_CMP && $past(state) == ST_CMP) |->
      $stable({ctrl.aluFn, ctrl.rdAddrA, ctrl.aSel, ctrl.bSel, ctrl.wrAddr}));
  // R3: the commit cycle is also the advance cycle
  a_r3_commit_advance: assert property (@(posedge clk) disable iff (rst)
    (state == ST_CMP && ctrl.wrEn) |=> (state == ST_BR));
  // R4: counter is zero on every compare entry
  a_r4_entry_zero: assert property (@(posedge clk) disable iff (rst)
    (state != ST_CMP && stateNext == ST_CMP) |=> (holdCnt == '0));
  // R9: matched is sticky while go is held
  a_r9_done_hold: assert property (@(posedge clk) disable iff (rst)
    (state == ST_DONE && go) |=> (state == ST_DONE));
  // R10: reset lands in idle with a clear counter
  a_r10_reset_idle: assert property (@(posedge clk)
    rst |=> (state == ST_IDLE && holdCnt == '0));
endmodule

// File: rtl/hold_ctrl_top.sv
module hold_ctrl_top
  import holdfsm_pkg::*;
#(
  parameter int DATA_W    = 16,
  parameter int HOLD_BITS = 4,
  parameter int ALU_LAT   = 6,
  parameter int CMP_CONST = 10
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              go,
  input  logic [DATA_W-1:0] loadValue,
  output logic [2:0]        stateCode,
  output logic              wrEn,
  output logic [2:0]        wrAddr,
  output logic [DATA_W-1:0] wrData,
  output logic              matched
);
  ctrl_t ctrl;
  logic  flagOne;

  hold_controller #(.HOLD_BITS(HOLD_BITS)) u_ctrl (
    .clk(clk), .rst(rst), .go(go), .flagOne(flagOne),
    .ctrl(ctrl), .stateCode(stateCode)
  );

  hold_datapath #(.DATA_W(DATA_W), .ALU_LAT(ALU_LAT), .CMP_CONST(CMP_CONST)) u_dp (
    .clk(clk), .rst(rst), .ctrl(ctrl), .loadValue(loadValue),
    .wrData(wrData), .flagOne(flagOne)
  );

  assign wrEn    = ctrl.wrEn;
  assign wrAddr  = ctrl.wrAddr;
  assign matched = (stateCode == ST_DONE);
endmodule

// File: tb/hold_ctrl_top_tb.sv
module hold_ctrl_top_tb;
  localparam int CLK_PERIOD = 10;
  localparam int HOLD_CYC = 16;
  localparam int KVAL = 10;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        go = 1'b0;
  logic [15:0] loadValue = '0;
  logic [2:0]  stateCode;
  logic        wrEn;
  logic [2:0]  wrAddr;
  logic [15:0] wrData;
  logic        matched;

  int errors = 0;
  int checks = 0;
  bit finished = 0;

  int mState, mCnt;
  logic [15:0] mR1, mR6;
  int prevObs, visitLen, visitWe;

  hold_ctrl_top u_dut (
    .clk(clk), .rst(rst), .go(go), .loadValue(loadValue),
    .stateCode(stateCode), .wrEn(wrEn), .wrAddr(wrAddr),
    .wrData(wrData), .matched(matched)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic logic expWe(int st, int cnt);
    return (st == 1) || (st == 4) || (st == 2 && cnt == HOLD_CYC - 1);
  endfunction

  function automatic logic [15:0] expData(int st, logic [15:0] r1, logic [15:0] lv);
    case (st)
      1: return lv;
      4: return r1 + 16'd1;
      default: return (r1 == 16'(KVAL)) ? 16'd1 : 16'd0;
    endcase
  endfunction

  task automatic modelReset();
    mState = 0; mCnt = 0; mR1 = '0; mR6 = '0;
    prevObs = 0; visitLen = 0; visitWe = 0;
  endtask

  task automatic step(input logic g, input logic [15:0] lv);
    @(negedge clk);
    go = g; loadValue = lv;
    #1;
    chk("R11 stateCode", stateCode, mState);
    chk("R9 matched", matched, (mState == 5));
    chk("R3 wrEn", wrEn, expWe(mState, mCnt));
    if (mState == 2) chk("R2 wrAddr held", wrAddr, 3'd6);
    if (expWe(mState, mCnt)) begin
      if (mState == 2) chk("R5 compare data", wrData, expData(2, mR1, lv));
      if (mState == 4) chk("R7 increment data", wrData, expData(4, mR1, lv));
      if (mState == 1) chk("R8 load data", wrData, lv);
      if (mState != 2) chk("R7 R8 score addr", wrAddr, 3'd1);
    end
    // per-visit bookkeeping from observed ports (R1, R3)
    if (stateCode == 3'd2) begin
      visitLen++;
      if (wrEn) visitWe++;
    end else if (prevObs == 2) begin
      chk("R1 visit length", visitLen, HOLD_CYC);
      chk("R3 one write per visit", visitWe, 1);
      chk("R6 branch after commit", stateCode, 3'd3);
      visitLen = 0; visitWe = 0;
    end
    prevObs = stateCode;
    // advance the reference
    case (mState)
      0: if (g) mState = 1;
      1: begin mR1 = lv; mState = 2; mCnt = 0; end
      2: if (mCnt == HOLD_CYC - 1) begin
           mR6 = (mR1 == 16'(KVAL)) ? 16'd1 : 16'd0; mState = 3; mCnt = 0;
         end else mCnt++;
      3: mState = (mR6 == 16'd1) ? 5 : 4;
      4: begin mR1 = mR1 + 16'd1; mState = 2; end
      5: if (!g) mState = 0;
      default: mState = 0;
    endcase
  endtask

  task automatic doReset();
    @(negedge clk);
    rst = 1'b1; go = 1'b0;
    repeat (2) @(negedge clk);
    rst = 1'b0;
    modelReset();
    #1;
    chk("R10 reset state", stateCode, 3'd0);
    chk("R10 reset wrEn", wrEn, 1'b0);
  endtask

  task automatic runScore(input logic [15:0] lv, input int extraHold);
    for (int n = 0; n < 3000 && mState != 5; n++) step(1'b1, lv);
    chk("R6 reached matched", mState, 5);
    for (int n = 0; n < extraHold; n++) step(1'b1, lv);
    step(1'b0, lv);
    step(1'b0, lv);
    chk("R9 back to idle", stateCode, 3'd0);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4711));
    modelReset();
    doReset();
    // R8: idle with go low stays idle, no write
    for (int n = 0; n < 3; n++) step(1'b0, 16'd7);
    chk("R8 idle holds", stateCode, 3'd0);
    // directed corners: immediate match, long climb, one below
    runScore(16'd10, 0);
    runScore(16'd0, 2);
    runScore(16'd9, 1);
    // R4 and R10: reset in the middle of a compare visit
    for (int n = 0; n < 8; n++) step(1'b1, 16'd4);
    chk("R4 mid-compare before reset", stateCode, 3'd2);
    doReset();
    runScore(16'd8, 0);
    // random scores within reach of the constant
    for (int r = 0; r < 10; r++) begin
      runScore(16'($urandom % 11), int'($urandom % 4));
    end
    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule